// File: doc/BRIEF.md
# Power-Good Strap Latch Controller

This block sits between the board strap pins of a clock generator and its synthesis core. At power-up the frequency-select straps and the debug-port strap are sampled once, when the active-low power-good strobe is first seen as a valid low. The sampled values then stay fixed until the next cold reset. From that point the same strobe pin has a second role. It becomes a live, level-sensitive power-down request that is active high.

The three-level frequency strap reaches the block as a two-bit level code. Its high level at the moment of capture selects test mode. In test mode the latch stays open so that the test straps can be changed on a running part. In this mode the second frequency strap chooses between high-impedance outputs and divided-reference outputs. In that reference mode the CPU output runs at REF/2, SRC at REF/8, PCI at REF/24, and REF, DOT96 and USB run at REF. Outside test mode the CPU frequency is one of 100, 133, 200 or 266 MHz. SRC stays at 100 MHz and PCI at 33 MHz. Before capture every output holds a safe default.

Top module: `pgood_strap_latch`

## Requirements
- R1: While reset is held, and after reset until capture, `cpu_sel` reads 0 (100 MHz), `itp_cpu2_sel`, `test_mode`, `test_ref_drive`, `out_hiz` and `power_down` all read 0, whatever the strap and strobe levels are.
- R2: The strobe goes through a two-flop synchronizer. Capture needs the synchronized level to be low on two consecutive clocks. With the default parameters, the outputs take the captured values after the fourth rising edge that follows a strobe fall. A strobe low that lasts a single clock captures nothing.
- R3: `cpu_sel` encodes 0 = 100, 1 = 133, 2 = 200 and 3 = 266 MHz. `fsc_lvl` encodes 00 = low, 01 = mid, 10 = high and 11 = mid. With FS_C low, {fsb_in, fsa_in} maps 00 to 3, 01 to 1, 10 to 2 and 11 to 0. With FS_C mid, `cpu_sel` is 0.
- R4: `itp_cpu2_sel` carries the debug strap value captured at the first valid low. A value of 1 routes the shared differential pair as CPU2 and 0 routes it as SRC7.
- R5: When capture happens outside test mode, later changes on the straps and later strobe edges leave `cpu_sel`, `itp_cpu2_sel` and `test_mode` unchanged.
- R6: After capture, `power_down` follows the strobe level with two rising edges of latency. High means power down. Before capture, `power_down` stays 0.
- R7: If `fsc_lvl` is high (10) at capture, `test_mode` is 1. While `test_mode` is 1, `cpu_sel` reads 0.
- R8: In test mode, `test_ref_drive` equals the held FS_B and `out_hiz` equals its inverse. Outside test mode both are 0.
- R9: In test mode the FS straps are reloaded on every clock, and the outputs show the new values one edge later. If the reloaded FS_C is not high, test mode ends and those values become final. The debug strap is never reloaded.
- R10: Asserting reset after a capture returns all outputs to the R1 defaults and rearms the one-shot capture. The next valid low captures fresh values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Cold reset, asynchronous active low |
| fsa_in | input | 1 | Frequency strap A |
| fsb_in | input | 1 | Frequency strap B, also test output select |
| fsc_lvl | input | 2 | Three-level frequency strap C as a level code |
| itp_strap_in | input | 1 | Debug-port routing strap |
| pwrgd_pd_in | input | 1 | Power-good strobe (active low) before capture, power-down request (active high) after |
| cpu_sel | output | 2 | Captured CPU frequency code |
| itp_cpu2_sel | output | 1 | 1 = shared pair is CPU2, 0 = SRC7 |
| test_mode | output | 1 | Test mode active |
| test_ref_drive | output | 1 | Test mode: drive divided reference |
| out_hiz | output | 1 | Test mode: all outputs high impedance |
| power_down | output | 1 | Live power-down request |

## Verification
Two functions can act on the same clock edge in test mode: the open latch reloads straps that take the part out of test mode, and the strobe rises to request power down. The bench changes FS_C to low and raises the strobe on the same falling edge. It then expects `test_mode` to drop with the new frequency code one edge later, while `power_down` rises one edge after that. Changes to the straps made afterwards must not move `cpu_sel`.

// File: rtl/pgl_pkg.sv
package pgl_pkg;

  typedef enum logic [1:0] {
    FSC_LOW  = 2'b00,
    FSC_MID  = 2'b01,
    FSC_HIGH = 2'b10,
    FSC_RSVD = 2'b11
  } fsc_lvl_e;

  typedef enum logic [1:0] {
    CPU_100 = 2'd0,
    CPU_133 = 2'd1,
    CPU_200 = 2'd2,
    CPU_266 = 2'd3
  } cpu_freq_e;

  typedef struct packed {
    logic     fs_a;
    logic     fs_b;
    fsc_lvl_e fs_c;
  } fs_straps_t;

  localparam fs_straps_t FS_SAFE = '{fs_a: 1'b1, fs_b: 1'b0, fs_c: FSC_MID};

endpackage

// File: rtl/pgl_rst_sync.sv
module pgl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pgl_strobe_qual.sv
module pgl_strobe_qual #(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_in,
  output logic strobe_sync,
  output logic valid_low
);

  localparam int HIST = QUAL_SAMPLES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d[0] = strobe_in;
    for (int i = 1; i < SYNC_STAGES; i++) begin
      sync_d[i] = sync_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign strobe_sync = sync_q[SYNC_STAGES-1];

  generate
    if (HIST > 0) begin : g_hist
      logic [HIST-1:0] hist_q;
      logic [HIST-1:0] hist_d;

      always_comb begin
        hist_d[0] = strobe_sync;
        for (int i = 1; i < HIST; i++) begin
          hist_d[i] = hist_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q <= '1;
        end else begin
          hist_q <= hist_d;
        end
      end

      assign valid_low = ~strobe_sync & ~(|hist_q);
    end else begin : g_nohist
      assign valid_low = ~strobe_sync;
    end
  endgenerate

endmodule

// File: rtl/pgl_strap_capture.sv
module pgl_strap_capture
  import pgl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid_low,
  input  fs_straps_t fs_in,
  input  logic       itp_in,
  output logic       captured,
  output logic       test_q,
  output fs_straps_t fs_q,
  output logic       itp_q
);

  logic       ld_first;
  logic       ld_track;
  logic       ld_fs;
  logic       test_d;
  fs_straps_t fs_d;
  logic       itp_d;
  logic       cap_q;

  always_comb begin
    ld_first = ~cap_q & valid_low;
    ld_track = cap_q & test_q;
    ld_fs    = ld_first | ld_track;
    fs_d     = fs_in;
    test_d   = (fs_in.fs_c == FSC_HIGH);
    itp_d    = itp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      test_q <= 1'b0;
      fs_q   <= FS_SAFE;
      itp_q  <= 1'b0;
    end else begin
      if (ld_fs) begin
        fs_q   <= fs_d;
        test_q <= test_d;
      end
      if (ld_first) begin
        itp_q <= itp_d;
        cap_q <= 1'b1;
      end
    end
  end

  assign captured = cap_q;

endmodule

// File: rtl/pgl_out_decode.sv
module pgl_out_decode
  import pgl_pkg::*;
(
  input  logic       captured,
  input  logic       test_q,
  input  fs_straps_t fs_q,
  input  logic       itp_q,
  input  logic       strobe_sync,
  output logic [1:0] cpu_sel,
  output logic       itp_cpu2_sel,
  output logic       test_mode,
  output logic       test_ref_drive,
  output logic       out_hiz,
  output logic       power_down
);

  cpu_freq_e freq;

  always_comb begin
    freq = CPU_100;
    if (captured && !test_q && fs_q.fs_c == FSC_LOW) begin
      case ({fs_q.fs_b, fs_q.fs_a})
        2'b00:   freq = CPU_266;
        2'b01:   freq = CPU_133;
        2'b10:   freq = CPU_200;
        default: freq = CPU_100;
      endcase
    end
  end

  assign cpu_sel        = freq;
  assign itp_cpu2_sel   = captured & itp_q;
  assign test_mode      = captured & test_q;
  assign test_ref_drive = test_mode & fs_q.fs_b;
  assign out_hiz        = test_mode & ~fs_q.fs_b;
  assign power_down     = captured & strobe_sync;

endmodule

// File: rtl/pgood_strap_latch.sv
module pgood_strap_latch
  import pgl_pkg::*;
#(
  parameter int RST_STAGES   = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_SAMPLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsa_in,
  input  logic       fsb_in,
  input  logic [1:0] fsc_lvl,
  input  logic       itp_strap_in,
  input  logic       pwrgd_pd_in,
  output logic [1:0] cpu_sel,
  output logic       itp_cpu2_sel,
  output logic       test_mode,
  output logic       test_ref_drive,
  output logic       out_hiz,
  output logic       power_down
);

  logic       rst_n_int;
  logic       strobe_sync;
  logic       valid_low;
  logic       cap_w;
  logic       test_w;
  logic       itp_w;
  fs_straps_t fs_in_w;
  fs_straps_t fs_held_w;

  assign fs_in_w = '{fs_a: fsa_in, fs_b: fsb_in, fs_c: fsc_lvl_e'(fsc_lvl)};

  pgl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  pgl_strobe_qual #(
    .SYNC_STAGES  (SYNC_STAGES),
    .QUAL_SAMPLES (QUAL_SAMPLES)
  ) u_qual (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .strobe_in   (pwrgd_pd_in),
    .strobe_sync (strobe_sync),
    .valid_low   (valid_low)
  );

  pgl_strap_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .valid_low (valid_low),
    .fs_in     (fs_in_w),
    .itp_in    (itp_strap_in),
    .captured  (cap_w),
    .test_q    (test_w),
    .fs_q      (fs_held_w),
    .itp_q     (itp_w)
  );

  pgl_out_decode u_dec (
    .captured       (cap_w),
    .test_q         (test_w),
    .fs_q           (fs_held_w),
    .itp_q          (itp_w),
    .strobe_sync    (strobe_sync),
    .cpu_sel        (cpu_sel),
    .itp_cpu2_sel   (itp_cpu2_sel),
    .test_mode      (test_mode),
    .test_ref_drive (test_ref_drive),
    .out_hiz        (out_hiz),
    .power_down     (power_down)
  );

endmodule

// File: rtl/pgl_checker.sv
module pgl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pwrgd_pd_in,
  input logic       captured,
  input logic [1:0] cpu_sel,
  input logic       itp_cpu2_sel,
  input logic       test_mode,
  input logic       test_ref_drive,
  input logic       out_hiz,
  input logic       power_down
);

  p_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !captured |-> (cpu_sel == 2'd0 && !itp_cpu2_sel && !test_mode && !power_down))
    else $error("p_defaults_r1");

  p_itp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && $past(captured)) |-> $stable(itp_cpu2_sel))
    else $error("p_itp_hold_r5");

  p_cpu_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (captured && $past(captured) && !test_mode && !$past(test_mode)) |-> $stable(cpu_sel))
    else $error("p_cpu_hold_r5");

  p_pd_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> $past(pwrgd_pd_in, 2))
    else $error("p_pd_source_r6");

  p_test_cpu_r7: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> cpu_sel == 2'd0)
    else $error("p_test_cpu_r7");

  p_test_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({test_ref_drive, out_hiz}) && ((test_ref_drive || out_hiz) == test_mode))
    else $error("p_test_sel_r8");

endmodule

bind pgood_strap_latch pgl_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pwrgd_pd_in    (pwrgd_pd_in),
  .captured       (cap_w),
  .cpu_sel        (cpu_sel),
  .itp_cpu2_sel   (itp_cpu2_sel),
  .test_mode      (test_mode),
  .test_ref_drive (test_ref_drive),
  .out_hiz        (out_hiz),
  .power_down     (power_down)
);

// File: tb/tb_pgood_strap_latch.sv
module tb_pgood_strap_latch;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {fsa, fsb, fsc[1:0], itp, exp_cpu[1:0], exp_test, exp_ref}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 2'b00, 1'b0, 2'd1, 1'b0, 1'b0},
    {1'b0, 1'b1, 2'b00, 1'b1, 2'd2, 1'b0, 1'b0},
    {1'b0, 1'b0, 2'b00, 1'b0, 2'd3, 1'b0, 1'b0},
    {1'b1, 1'b1, 2'b00, 1'b1, 2'd0, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'b01, 1'b0, 2'd0, 1'b0, 1'b0},
    {1'b0, 1'b1, 2'b01, 1'b1, 2'd0, 1'b0, 1'b0},
    {1'b0, 1'b0, 2'b11, 1'b0, 2'd0, 1'b0, 1'b0},
    {1'b1, 1'b0, 2'b10, 1'b1, 2'd0, 1'b1, 1'b0},
    {1'b0, 1'b1, 2'b10, 1'b0, 2'd0, 1'b1, 1'b1}
  };

  logic       clk;
  logic       rst_n;
  logic       fsa_in;
  logic       fsb_in;
  logic [1:0] fsc_lvl;
  logic       itp_strap_in;
  logic       pwrgd_pd_in;
  logic [1:0] cpu_sel;
  logic       itp_cpu2_sel;
  logic       test_mode;
  logic       test_ref_drive;
  logic       out_hiz;
  logic       power_down;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  pgood_strap_latch dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .fsa_in         (fsa_in),
    .fsb_in         (fsb_in),
    .fsc_lvl        (fsc_lvl),
    .itp_strap_in   (itp_strap_in),
    .pwrgd_pd_in    (pwrgd_pd_in),
    .cpu_sel        (cpu_sel),
    .itp_cpu2_sel   (itp_cpu2_sel),
    .test_mode      (test_mode),
    .test_ref_drive (test_ref_drive),
    .out_hiz        (out_hiz),
    .power_down     (power_down)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_defaults(input string tag);
    chk({tag, " cpu_sel"}, cpu_sel, 0);
    chk({tag, " itp"}, itp_cpu2_sel, 0);
    chk({tag, " test_mode"}, test_mode, 0);
    chk({tag, " ref_drive"}, test_ref_drive, 0);
    chk({tag, " hiz"}, out_hiz, 0);
    chk({tag, " power_down"}, power_down, 0);
  endtask

  task automatic do_reset();
    pwrgd_pd_in = 1'b1;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic set_straps(input logic a, input logic b, input logic [1:0] c, input logic itp);
    fsa_in = a;
    fsb_in = b;
    fsc_lvl = c;
    itp_strap_in = itp;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pwrgd_pd_in = 1'b0;
    set_straps(1'b0, 1'b0, 2'b00, 1'b1);
    tick(3);
    chk_defaults("R1 in reset");
    do_reset();
    chk_defaults("R1 after reset");

    // table walk: R2 capture latency, R3/R4/R7/R8 decode, R5 one-shot
    for (int v = 0; v < NVEC; v++) begin
      logic [8:0] e;
      e = VEC[v];
      do_reset();
      set_straps(e[8], e[7], e[6:5], e[4]);
      tick(3);
      chk("R6 no pd before capture", power_down, 0);
      pwrgd_pd_in = 1'b0;
      tick(3);
      chk("R2 not yet captured", itp_cpu2_sel | test_mode | cpu_sel, 0);
      tick(1);
      chk("R3 cpu_sel", cpu_sel, e[3:2]);
      chk("R4 itp select", itp_cpu2_sel, e[4]);
      chk("R7 test_mode", test_mode, e[1]);
      chk("R8 ref_drive", test_ref_drive, e[0]);
      chk("R8 hiz", out_hiz, e[1] & ~e[0]);
      if (!e[1]) begin
        set_straps(~e[8], ~e[7], 2'b10, ~e[4]);
        pwrgd_pd_in = 1'b1;
        tick(2);
        pwrgd_pd_in = 1'b0;
        tick(4);
        chk("R5 cpu held", cpu_sel, e[3:2]);
        chk("R5 itp held", itp_cpu2_sel, e[4]);
        chk("R5 no test entry", test_mode, 0);
      end
    end

    // R2 single-cycle glitch does not capture
    do_reset();
    set_straps(1'b0, 1'b0, 2'b00, 1'b1);
    tick(3);
    pwrgd_pd_in = 1'b0;
    tick(1);
    pwrgd_pd_in = 1'b1;
    tick(6);
    chk("R2 glitch cpu", cpu_sel, 0);
    chk("R2 glitch itp", itp_cpu2_sel, 0);
    pwrgd_pd_in = 1'b0;
    tick(4);
    chk("R2 capture after glitch", cpu_sel, 3);

    // R6 power-down latency
    pwrgd_pd_in = 1'b1;
    tick(1);
    chk("R6 pd latency 1", power_down, 0);
    tick(1);
    chk("R6 pd asserted", power_down, 1);
    chk("R6 cpu kept under pd", cpu_sel, 3);
    pwrgd_pd_in = 1'b0;
    tick(1);
    chk("R6 pd hold 1", power_down, 1);
    tick(1);
    chk("R6 pd released", power_down, 0);

    // R9 test mode tracking and exit colliding with power-down
    do_reset();
    set_straps(1'b0, 1'b0, 2'b10, 1'b1);
    pwrgd_pd_in = 1'b0;
    tick(4);
    chk("R7 test entry", test_mode, 1);
    chk("R8 hiz in test", out_hiz, 1);
    fsb_in = 1'b1;
    tick(1);
    chk("R9 fsb reloaded", test_ref_drive, 1);
    chk("R9 hiz cleared", out_hiz, 0);
    itp_strap_in = 1'b0;
    tick(1);
    chk("R9 itp not reloaded", itp_cpu2_sel, 1);
    set_straps(1'b1, 1'b0, 2'b00, 1'b0);
    pwrgd_pd_in = 1'b1;
    tick(1);
    chk("R9 test exit", test_mode, 0);
    chk("R9 exit code", cpu_sel, 1);
    chk("R6 pd not yet", power_down, 0);
    tick(1);
    chk("R6 pd with exit", power_down, 1);
    fsa_in = 1'b0;
    tick(2);
    chk("R9 latch closed", cpu_sel, 1);

    // R10 reset rearms capture
    rst_n = 1'b0;
    tick(1);
    chk_defaults("R10 reset clears");
    set_straps(1'b0, 1'b1, 2'b00, 1'b1);
    pwrgd_pd_in = 1'b0;
    rst_n = 1'b1;
    tick(10);
    chk("R10 recapture cpu", cpu_sel, 2);
    chk("R10 recapture itp", itp_cpu2_sel, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule